// File: doc/BRIEF.md
# Rational-Modulus Sigma-Delta Divide-Value Generator

This block feeds the loop divider of a fractional-N synthesizer. On every phase-detector clock it presents a new integer divide value. That value is a programmed integer part plus a small signed correction drawn from a cascade of up to three first-order accumulators. Over time the average divide value equals N + NUM/DEN. The accumulators wrap at a programmable 32-bit modulus DEN rather than at a power of two, so ratios such as 1/3 or 7/1000 come out exactly.

Software writes the integer part, the numerator, the modulus and the shaping order through a small parallel write port into staging registers. A single load strobe commits all four at once and restarts the accumulators from zero.

The order can be changed at run time. Order 0 gives plain integer division, and orders 1 to 3 give increasingly steep noise shaping with wider correction swings. A larger order therefore needs a larger integer part so that the output stays above the divider's floor. If N plus the correction would drop below that floor, the output is held at the floor and an error flag is raised for that cycle.

Top module: `mash_ndiv_gen`

## Requirements
- R1: After reset the divide output is MIN_DIV (12), the error flag is low, and the active setting is N=12, NUM=0, DEN=1, order 0. The output then stays at 12 every cycle until a load occurs.
- R2: A write with `wr_en` high stores `wr_data` into a staging register chosen by `wr_sel`: 0 = integer part (bits 14:0), 1 = numerator, 2 = modulus, 3 = order (bits 1:0). Staged values have no effect on the output until a load.
- R3: In the clock edge where `load` is high, all four staged values become active together and every accumulator and carry-history register clears to zero. The output registered at that edge equals the new integer part, with no correction.
- R4: Each accumulator stage adds its input to its state and subtracts DEN whenever the sum is at least DEN. It emits a carry of 1 in that cycle, and its state always stays below DEN. Stage 1 adds NUM, stage 2 adds stage 1's new state, and stage 3 adds stage 2's new state.
- R5: With order 0, the output equals the integer part in every cycle.
- R6: With order 1, the correction is the stage-1 carry (0 or +1). Over any DEN consecutive cycles after a load, the corrections sum to exactly NUM.
- R7: With carries c1..c3 of the current cycle, order 2 adds c1 + c2 − c2[n−1]. Order 3 further adds c3 − 2·c3[n−1] + c3[n−2]. The correction spans −1..+2 for order 2 and −3..+4 for order 3, and the output is registered one cycle after the step.
- R8: After k steps from a load, the cumulative correction minus floor(k·NUM/DEN) lies in [0,1] for order 2 and in [−1,2] for order 3.
- R9: When N plus the correction is below MIN_DIV, the output is MIN_DIV and `div_err` is high in that same cycle. Otherwise `div_err` is low.
- R10: Moduli up to 2^32−1, with numerators up to DEN−1, accumulate without overflow, and outputs up to 32767+4 are represented.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase-detector clock; one modulator step per rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Staging-register write enable |
| wr_sel | input | 2 | Staging register select (0 N, 1 NUM, 2 DEN, 3 order) |
| wr_data | input | 32 | Write data |
| load | input | 1 | Commit staged setting and clear the modulator |
| div_out | output | 16 | Divide value for the current reference cycle |
| div_err | output | 1 | Output held at floor because N plus correction was too low |

## Verification
The bench builds the block with its default parameters (15-bit integer, 32-bit modulus, floor 12). It drives very small moduli (1, 2, 3, 5, 7, 16, 97) so that every numerator of the small moduli can be swept under all four orders. Each run is long enough to cover two full modulus periods, which makes the exact window-sum property of first order and the cumulative bounds of the higher orders checkable against an arithmetic model. Directed runs add moduli near 2^32, an integer part of 32767 at the top of the range, and an integer part at the floor so that clamping and the error flag are exercised.

// File: rtl/mash_pkg.sv
// Shared types and constants for the divide-value generator.
// Assumes three cascaded accumulator stages and a 4-bit signed correction.
package mash_pkg;

    localparam int NUM_STAGES = 3;
    localparam int CORR_W     = 4;

    // Noise-shaping order; value encodes the number of active stages.
    typedef enum logic [1:0] {
        ORD_INT = 2'd0,
        ORD_1   = 2'd1,
        ORD_2   = 2'd2,
        ORD_3   = 2'd3
    } ord_e;

    // Staging register select for the write port.
    typedef enum logic [1:0] {
        SEL_N   = 2'd0,
        SEL_NUM = 2'd1,
        SEL_DEN = 2'd2,
        SEL_ORD = 2'd3
    } wsel_e;

endpackage

// File: rtl/mash_cfg_regs.sv
// Staging and active copies of the programmed setting.
// Writes land in the staging copy; a load moves all four fields to the
// active copy in one edge. A write and a load in the same cycle: the load
// commits the staging values as they stood before that write.
module mash_cfg_regs
    import mash_pkg::*;
#(
    parameter int N_W     = 15,
    parameter int F_W     = 32,
    parameter int MIN_DIV = 12
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en,
    input  logic [1:0]     wr_sel,
    input  logic [F_W-1:0] wr_data,
    input  logic           load,
    output logic [N_W-1:0] shd_n,
    output logic [N_W-1:0] act_n,
    output logic [F_W-1:0] act_num,
    output logic [F_W-1:0] act_den,
    output ord_e           act_ord
);

    localparam logic [N_W-1:0] RST_N = N_W'(MIN_DIV);

    logic [F_W-1:0] shd_num;
    logic [F_W-1:0] shd_den;
    ord_e           shd_ord;

    // Capture port writes into the staging copy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shd_n   <= RST_N;
            shd_num <= '0;
            shd_den <= F_W'(1);
            shd_ord <= ORD_INT;
        end else if (wr_en) begin
            case (wsel_e'(wr_sel))
                SEL_N:   shd_n   <= wr_data[N_W-1:0];
                SEL_NUM: shd_num <= wr_data;
                SEL_DEN: shd_den <= wr_data;
                SEL_ORD: shd_ord <= ord_e'(wr_data[1:0]);
                default: ;
            endcase
        end
    end

    // Commit the whole staging copy on a load strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            act_n   <= RST_N;
            act_num <= '0;
            act_den <= F_W'(1);
            act_ord <= ORD_INT;
        end else if (load) begin
            act_n   <= shd_n;
            act_num <= shd_num;
            act_den <= shd_den;
            act_ord <= shd_ord;
        end
    end

endmodule

// File: rtl/mash_acc_stage.sv
// One modulo-DEN accumulator. The next state and carry are combinational
// so stages chain within a single cycle; the state register clears on clr.
// Assumes x < den and state < den, so one subtraction always suffices.
module mash_acc_stage #(
    parameter int F_W = 32
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           clr,
    input  logic [F_W-1:0] x,
    input  logic [F_W-1:0] den,
    output logic [F_W-1:0] acc_q,
    output logic [F_W-1:0] acc_nxt,
    output logic           carry
);

    logic [F_W:0] sum;
    logic [F_W:0] wrapped;

    // Add the input and fold back by the modulus when the sum reaches it.
    always_comb begin
        sum     = {1'b0, acc_q} + {1'b0, x};
        wrapped = sum - {1'b0, den};
        carry   = (sum >= {1'b0, den});
        acc_nxt = carry ? wrapped[F_W-1:0] : sum[F_W-1:0];
    end

    // Hold the accumulator state between reference cycles.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) acc_q <= '0;
        else               acc_q <= acc_nxt;
    end

endmodule

// File: rtl/mash_cancel.sv
// Error-cancelling recombination of the stage carries, selected by order.
// Keeps one delayed stage-2 carry and two delayed stage-3 carries; all
// history clears on clr so a restart begins from zero past.
module mash_cancel
    import mash_pkg::*;
(
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clr,
    input  logic [NUM_STAGES-1:0]    c_now,
    input  ord_e                     ord,
    output logic signed [CORR_W-1:0] corr
);

    logic c2_d1;
    logic c3_d1;
    logic c3_d2;
    logic signed [CORR_W-1:0] t1;
    logic signed [CORR_W-1:0] t2;
    logic signed [CORR_W-1:0] t3;

    // Delay line for the carries that the difference terms need.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            c2_d1 <= 1'b0;
            c3_d1 <= 1'b0;
            c3_d2 <= 1'b0;
        end else begin
            c2_d1 <= c_now[1];
            c3_d1 <= c_now[2];
            c3_d2 <= c3_d1;
        end
    end

    // First, first-difference and second-difference terms.
    always_comb begin
        t1 = {{(CORR_W-1){1'b0}}, c_now[0]};
        t2 = {{(CORR_W-1){1'b0}}, c_now[1]} - {{(CORR_W-1){1'b0}}, c2_d1};
        t3 = {{(CORR_W-1){1'b0}}, c_now[2]}
           - {{(CORR_W-2){1'b0}}, c3_d1, 1'b0}
           + {{(CORR_W-1){1'b0}}, c3_d2};
    end

    // Pick how many terms contribute according to the order.
    always_comb begin
        case (ord)
            ORD_INT: corr = '0;
            ORD_1:   corr = t1;
            ORD_2:   corr = t1 + t2;
            default: corr = t1 + t2 + t3;
        endcase
    end

endmodule

// File: rtl/mash_ndiv_gen.sv
// Top level: per-reference-cycle divide value for a fractional-N divider.
// Output register holds N plus the signed correction, floored at MIN_DIV
// with div_err marking a floored cycle. Assumes NUM < DEN and DEN >= 1.
module mash_ndiv_gen
    import mash_pkg::*;
#(
    parameter int N_W     = 15,
    parameter int F_W     = 32,
    parameter int MIN_DIV = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [1:0]       wr_sel,
    input  logic [F_W-1:0]   wr_data,
    input  logic             load,
    output logic [N_W:0]     div_out,
    output logic             div_err
);

    localparam int OUT_W = N_W + 1;
    localparam int SUM_W = N_W + 2;
    localparam logic signed [SUM_W-1:0] MIN_S = SUM_W'(MIN_DIV);

    logic [N_W-1:0] shd_n;
    logic [N_W-1:0] act_n;
    logic [F_W-1:0] act_num;
    logic [F_W-1:0] act_den;
    ord_e           act_ord;

    logic [NUM_STAGES-1:0][F_W-1:0] acc_q;
    logic [NUM_STAGES-1:0][F_W-1:0] acc_nxt;
    logic [NUM_STAGES-1:0][F_W-1:0] stg_in;
    logic [NUM_STAGES-1:0]          carry;

    logic signed [CORR_W-1:0] corr;
    logic signed [CORR_W-1:0] corr_use;
    logic [N_W-1:0]           base_n;
    logic signed [SUM_W-1:0]  total;
    logic                     below;

    mash_cfg_regs #(
        .N_W     (N_W),
        .F_W     (F_W),
        .MIN_DIV (MIN_DIV)
    ) u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .load    (load),
        .shd_n   (shd_n),
        .act_n   (act_n),
        .act_num (act_num),
        .act_den (act_den),
        .act_ord (act_ord)
    );

    // Cascade: first stage takes NUM, each later one the previous new state.
    for (genvar g = 0; g < NUM_STAGES; g++) begin : g_stage
        if (g == 0) begin : g_head
            assign stg_in[g] = act_num;
        end else begin : g_tail
            assign stg_in[g] = acc_nxt[g-1];
        end

        mash_acc_stage #(
            .F_W (F_W)
        ) u_acc (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (load),
            .x       (stg_in[g]),
            .den     (act_den),
            .acc_q   (acc_q[g]),
            .acc_nxt (acc_nxt[g]),
            .carry   (carry[g])
        );
    end

    mash_cancel u_cancel (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (load),
        .c_now (carry),
        .ord   (act_ord),
        .corr  (corr)
    );

    // On a load the new integer part goes out unchanged; otherwise add the correction.
    always_comb begin
        base_n   = load ? shd_n : act_n;
        corr_use = load ? '0 : corr;
        total    = $signed({2'b00, base_n})
                 + {{(SUM_W-CORR_W){corr_use[CORR_W-1]}}, corr_use};
        below    = (total < MIN_S);
    end

    // Register the divide value, flooring it and flagging the floored cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_out <= OUT_W'(MIN_DIV);
            div_err <= 1'b0;
        end else begin
            div_out <= below ? OUT_W'(MIN_DIV) : total[OUT_W-1:0];
            div_err <= below;
        end
    end

endmodule

// File: rtl/mash_ndiv_chk.sv
// Property checker for mash_ndiv_gen, attached by bind below.
// Observes the output register, the active setting and accumulator states.
module mash_ndiv_chk
    import mash_pkg::*;
#(
    parameter int N_W     = 15,
    parameter int F_W     = 32,
    parameter int MIN_DIV = 12
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           load,
    input logic [N_W:0]                   div_out,
    input logic                           div_err,
    input logic [N_W-1:0]                 act_n,
    input logic [F_W-1:0]                 act_num,
    input logic [F_W-1:0]                 act_den,
    input ord_e                           act_ord,
    input logic [NUM_STAGES-1:0][F_W-1:0] acc_q
);

    logic signed [N_W+2:0] diff;

    // Signed distance between the output and the active integer part.
    always_comb diff = $signed({2'b00, div_out}) - $signed({3'b000, act_n});

    assert_floor_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (32'(div_out) >= MIN_DIV));

    assert_err_pins_floor_R9: assert property (@(posedge clk) disable iff (!rst_n)
        div_err |-> (32'(div_out) == MIN_DIV));

    assert_load_plain_n_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(load) && !div_err) |-> (div_out == {1'b0, act_n}));

    assert_int_mode_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (act_ord == ORD_INT && 32'(act_n) >= MIN_DIV) |-> (div_out == {1'b0, act_n}));

    assert_order1_span_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (act_ord == ORD_1 && !div_err) |-> (diff == 0 || diff == 1));

    assert_corr_span_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !div_err |-> (diff >= -3 && diff <= 4));

    for (genvar g = 0; g < NUM_STAGES; g++) begin : g_rng
        assert_acc_below_den_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (act_num < act_den) |-> (acc_q[g] < act_den));
    end

endmodule

bind mash_ndiv_gen mash_ndiv_chk #(
    .N_W     (N_W),
    .F_W     (F_W),
    .MIN_DIV (MIN_DIV)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (load),
    .div_out (div_out),
    .div_err (div_err),
    .act_n   (act_n),
    .act_num (act_num),
    .act_den (act_den),
    .act_ord (act_ord),
    .acc_q   (acc_q)
);

// File: tb/test_mash_ndiv_gen.sv
// Sweep bench: small moduli under all orders plus directed wide-modulus,
// floor and staging cases, against an arithmetic model of the requirements.
module test_mash_ndiv_gen;

    localparam int N_W     = 15;
    localparam int F_W     = 32;
    localparam int MIN_DIV = 12;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           wr_en = 1'b0;
    logic [1:0]     wr_sel = 2'd0;
    logic [F_W-1:0] wr_data = '0;
    logic           load = 1'b0;
    logic [N_W:0]   div_out;
    logic           div_err;

    mash_ndiv_gen #(
        .N_W     (N_W),
        .F_W     (F_W),
        .MIN_DIV (MIN_DIV)
    ) i_mash_ndiv_gen (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .load    (load),
        .div_out (div_out),
        .div_err (div_err)
    );

    always #2 clk = ~clk;

    int     n_chk = 0;
    int     n_bad = 0;
    int     err_cnt = 0;
    longint m_n, m_num, m_den, m_ord;
    longint s_n, s_num, s_den, s_ord;
    longint m_a1, m_a2, m_a3;
    int     m_c2d, m_c3d1, m_c3d2;
    longint cum, steps;
    int     obs [0:1023];

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic acc_add(inout longint a, input longint x, output int c);
        longint s;
        s = a + x;
        c = (s >= m_den) ? 1 : 0;
        a = (c == 1) ? s - m_den : s;
    endtask

    task automatic m_step(output longint e_out, output bit e_err);
        int c1, c2, c3, corr;
        acc_add(m_a1, m_num, c1);
        acc_add(m_a2, m_a1, c2);
        acc_add(m_a3, m_a2, c3);
        case (m_ord)
            0: corr = 0;
            1: corr = c1;
            2: corr = c1 + c2 - m_c2d;
            default: corr = c1 + c2 - m_c2d + c3 - 2 * m_c3d1 + m_c3d2;
        endcase
        m_c2d  = c2;
        m_c3d2 = m_c3d1;
        m_c3d1 = c3;
        e_out = m_n + corr;
        e_err = (e_out < MIN_DIV);
        if (e_err) e_out = MIN_DIV;
    endtask

    task automatic cyc(input string req);
        longint eo;
        bit     ee;
        @(negedge clk);
        m_step(eo, ee);
        chk(longint'(div_out) == eo && div_err == ee, req, longint'(div_out), eo);
        if (div_err) err_cnt++;
        if (steps < 1024) obs[steps] = int'(div_out) - int'(m_n);
        cum += longint'(div_out) - m_n;
        steps++;
    endtask

    task automatic wr(input logic [1:0] sel, input longint data);
        wr_sel  = sel;
        wr_data = data[F_W-1:0];
        wr_en   = 1'b1;
        case (sel)
            2'd0: s_n = data & 32'h7FFF;
            2'd1: s_num = data;
            2'd2: s_den = data;
            default: s_ord = data & 3;
        endcase
        cyc("R2");
        wr_en = 1'b0;
    endtask

    task automatic do_load();
        longint e;
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        m_n = s_n; m_num = s_num; m_den = s_den; m_ord = s_ord;
        m_a1 = 0; m_a2 = 0; m_a3 = 0;
        m_c2d = 0; m_c3d1 = 0; m_c3d2 = 0;
        cum = 0; steps = 0;
        e = (m_n < MIN_DIV) ? MIN_DIV : m_n;
        chk(longint'(div_out) == e, "R3", longint'(div_out), e);
    endtask

    task automatic run(input longint n, input longint num, input longint den,
                       input longint ord, input int cycles, input string tag);
        string  t;
        longint dev, fl, ws;
        wr(2'd0, n);
        wr(2'd1, num);
        wr(2'd2, den);
        wr(2'd3, ord);
        do_load();
        if (tag != "") t = tag;
        else if (ord == 0) t = "R5";
        else if (ord == 1) t = "R6";
        else t = "R7";
        for (int k = 0; k < cycles; k++) begin
            cyc(t);
            if (ord >= 2 && n >= 16) begin
                fl  = (steps * num) / den;
                dev = cum - fl;
                if (ord == 2) chk(dev >= 0 && dev <= 1, "R8", dev, 0);
                else          chk(dev >= -1 && dev <= 2, "R8", dev, 0);
            end
        end
        if (ord == 1 && n >= 16 && 2 * den <= longint'(cycles) && cycles <= 1024) begin
            for (int s = 0; s < int'(den); s++) begin
                ws = 0;
                for (int j = 0; j < int'(den); j++) ws += obs[s + j];
                chk(ws == num, "R6", ws, num);
            end
        end
    endtask

    // Watchdog: a hung run is a failed check and still prints the summary.
    initial begin
        #(4 * 200000);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int dens [7] = '{1, 2, 3, 5, 7, 16, 97};
        m_n = MIN_DIV; m_num = 0; m_den = 1; m_ord = 0;
        s_n = MIN_DIV; s_num = 0; s_den = 1; s_ord = 0;
        m_a1 = 0; m_a2 = 0; m_a3 = 0;
        m_c2d = 0; m_c3d1 = 0; m_c3d2 = 0;
        cum = 0; steps = 0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the port
        chk(longint'(div_out) == MIN_DIV, "R1", longint'(div_out), MIN_DIV);
        chk(div_err == 1'b0, "R1", longint'(div_err), 0);
        repeat (4) cyc("R1");

        // R4: directed modular wrap with first-order carries
        run(300, 3, 5, 1, 20, "R4");
        run(300, 4, 5, 1, 20, "R4");

        // R2: staged writes leave the running sequence untouched until load
        run(500, 3, 7, 1, 20, "");
        wr(2'd0, 900);
        wr(2'd1, 5);
        wr(2'd2, 11);
        wr(2'd3, 3);
        repeat (6) cyc("R2");
        do_load();
        repeat (40) cyc("R7");

        // R3: same setting reloaded restarts the identical sequence
        run(1000, 2, 9, 3, 30, "R3");
        run(1000, 2, 9, 3, 30, "R3");

        // Sweep: every order, small moduli, many numerators
        for (int o = 0; o < 4; o++) begin
            for (int di = 0; di < 7; di++) begin
                for (int nm = 0; nm < dens[di]; nm += (dens[di] > 20) ? 7 : 1) begin
                    run(1000, nm, dens[di], o, 2 * dens[di] + 8, "");
                end
            end
        end

        // R10: moduli at the top of the 32-bit range
        run(20000, 64'hFFFF_FFFE, 64'hFFFF_FFFF, 3, 300, "R10");
        run(32767, 64'h7FFF_FFFF, 64'h8000_0001, 2, 300, "R10");
        run(32767, 64'hFFFF_FFFE, 64'hFFFF_FFFF, 3, 300, "R10");
        run(5000, 1, 64'hFFFF_FFFF, 1, 100, "R10");

        // R9: integer part at the floor under third order must clamp
        err_cnt = 0;
        run(12, 41, 97, 3, 200, "R9");
        chk(err_cnt > 0, "R9", err_cnt, 1);
        err_cnt = 0;
        run(5, 0, 1, 0, 10, "R9");
        chk(err_cnt == 10, "R9", err_cnt, 10);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule